// File: doc/BRIEF.md
# One-Bit Quadrature Downconverter

This block brings a single-bit oversampled bitstream, such as the output of a sigma-delta front end running at the system clock, down to complex baseband. It contains a tunable digital oscillator and a sign-flip mixer. Each clock, a 32-bit phase accumulator adds a programmable tuning word. The ten most significant accumulator bits address a quarter-wave sine table, and the block reads it twice: once at the raw phase for the sine word and once a quarter turn ahead for the cosine word.

The mixer needs no multiplier because the input is only one bit wide. A 0 passes both oscillator words through unchanged. A 1 rotates them by half a turn, which means it negates them, with saturation so that the result stays inside the symmetric range. The outputs are registered signed in-phase and quadrature samples, one pair per clock, ready for a decimating filter. Software can retune the carrier while the block runs by loading a new tuning word. The load does not disturb the running phase.

The block has no state machine. Its only sequential parts are the tuning register, the accumulator and the two output registers.

Top module: `onebit_iq_downconverter`

## Requirements
- R1: While rst_n is low, i_out and q_out read 0, and both the accumulator and the tuning register are cleared. The first sample after release is therefore taken at phase 0, and no load strobe seen during reset has any effect.
- R2: Take p as accumulator bits [31:22]. With the sampled data bit at 0, i_out equals round(2047·cos(2π(p+0.5)/1024)) and q_out equals round(2047·sin(2π(p+0.5)/1024)), each within ±2 LSB.
- R3: With the sampled data bit at 1, both i_out and q_out are the arithmetic negation of the R2 values.
- R4: The accumulator adds the tuning register once per clock. The sample that appears after a clock edge reflects the accumulator value held just before that edge and the data bit sampled at that edge.
- R5: The accumulator wraps modulo 2^32, so the phase keeps running smoothly across a full turn.
- R6: A tuning word presented with step_load high is captured at that edge and first added at the following edge. A reload never resets the accumulator, so phase stays continuous.
- R7: Neither output ever takes the code -2048, because negation saturates the most negative code to +2047.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the bitstream sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_bit | input | 1 | One-bit input sample |
| step_load | input | 1 | Strobe that captures step_word |
| step_word | input | 32 | Phase increment (tuning word) |
| i_out | output | 12 | Signed in-phase sample |
| q_out | output | 12 | Signed quadrature sample |

## Verification
The hardest case to reach from the ports is a retune in the middle of a rotation. For that case the bench has to show that the new increment starts exactly one edge after the strobe and that the phase carries on from where it was, rather than restarting at zero. The bench first runs one phase step per clock for more than a full turn, which crosses the accumulator wrap. It then reloads odd tuning words at arbitrary phases while feeding a pseudo-random bitstream. A cycle-exact accumulator model in the bench predicts every sample of this sequence.

// File: rtl/iq_dc_pkg.sv
package iq_dc_pkg;

    // Quarter-wave entry k of a table with `depth` entries, sampled at the
    // bin centre: round(amp * sin(pi/2 * (k + 0.5) / depth)).
    // Fixed-point Taylor series in Q30, evaluated at elaboration.
    function automatic int quarter_sine(input int k, input int depth, input int amp);
        longint x;
        longint x2;
        longint term;
        longint acc;
        x    = (64'sd3373259426 * longint'(2 * k + 1)) / longint'(4 * depth);
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int n = 1; n < 8; n++) begin
            term = ((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
            if (n % 2 == 1) acc = acc - term;
            else            acc = acc + term;
        end
        return int'((acc * longint'(amp) + 64'sd536870912) >>> 30);
    endfunction

endpackage

// File: rtl/iq_phase_accum.sv
module iq_phase_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_load,
    input  logic [ACC_W-1:0] step_word,
    output logic [ACC_W-1:0] step_q,
    output logic [ACC_W-1:0] acc_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (step_load) begin
            step_q <= step_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + step_q;
        end
    end

endmodule

// File: rtl/iq_quarter_lut.sv
module iq_quarter_lut
    import iq_dc_pkg::*;
#(
    parameter int PH_W  = 10,
    parameter int AMP_W = 12
) (
    input  logic [PH_W-1:0]         phase,
    output logic signed [AMP_W-1:0] wave
);

    localparam int IDX_W  = PH_W - 2;
    localparam int QDEPTH = 1 << IDX_W;
    localparam int PEAK   = (1 << (AMP_W - 1)) - 1;

    logic signed [AMP_W-1:0] qtab [QDEPTH];

    for (genvar gi = 0; gi < QDEPTH; gi++) begin : g_tab
        localparam int VAL = quarter_sine(gi, QDEPTH, PEAK);
        assign qtab[gi] = AMP_W'(VAL);
    end

    logic             mirror;
    logic             flip;
    logic [IDX_W-1:0] addr;
    logic signed [AMP_W-1:0] mag;

    always_comb begin
        mirror = phase[PH_W-2];
        flip   = phase[PH_W-1];
        addr   = mirror ? ~phase[IDX_W-1:0] : phase[IDX_W-1:0];
        mag    = qtab[addr];
        wave   = flip ? -mag : mag;
    end

endmodule

// File: rtl/iq_sign_mixer.sv
module iq_sign_mixer #(
    parameter int AMP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flip_bit,
    input  logic signed [AMP_W-1:0] lo_word,
    output logic signed [AMP_W-1:0] mixed
);

    localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};
    localparam logic signed [AMP_W-1:0] MOST_POS = {1'b0, {(AMP_W-1){1'b1}}};

    logic signed [AMP_W-1:0] negated;

    always_comb begin
        negated = (lo_word == MOST_NEG) ? MOST_POS : -lo_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mixed <= '0;
        end else begin
            mixed <= flip_bit ? negated : lo_word;
        end
    end

endmodule

// File: rtl/onebit_iq_downconverter.sv
module onebit_iq_downconverter #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 10,
    parameter int AMP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rf_bit,
    input  logic                    step_load,
    input  logic [ACC_W-1:0]        step_word,
    output logic signed [AMP_W-1:0] i_out,
    output logic signed [AMP_W-1:0] q_out
);

    localparam int QTR = 1 << (PH_W - 2);

    logic [ACC_W-1:0]        step_q;
    logic [ACC_W-1:0]        acc_q;
    logic [PH_W-1:0]         ph [2];
    logic signed [AMP_W-1:0] raw [2];
    logic signed [AMP_W-1:0] res [2];
    logic signed [AMP_W-1:0] sin_raw;
    logic signed [AMP_W-1:0] cos_raw;

    iq_phase_accum #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_load (step_load),
        .step_word (step_word),
        .step_q    (step_q),
        .acc_q     (acc_q)
    );

    always_comb begin
        ph[0] = acc_q[ACC_W-1 -: PH_W];
        ph[1] = acc_q[ACC_W-1 -: PH_W] + PH_W'(QTR);
    end

    // channel 0: sine -> Q, channel 1: cosine -> I
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        iq_quarter_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_lut (
            .phase (ph[ch]),
            .wave  (raw[ch])
        );
        iq_sign_mixer #(.AMP_W(AMP_W)) u_mix (
            .clk      (clk),
            .rst_n    (rst_n),
            .flip_bit (rf_bit),
            .lo_word  (raw[ch]),
            .mixed    (res[ch])
        );
    end

    assign sin_raw = raw[0];
    assign cos_raw = raw[1];
    assign q_out   = res[0];
    assign i_out   = res[1];

endmodule

// File: rtl/iq_dc_checker.sv
module iq_dc_checker #(
    parameter int ACC_W = 32,
    parameter int AMP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rf_bit,
    input  logic                    step_load,
    input  logic [ACC_W-1:0]        step_word,
    input  logic [ACC_W-1:0]        step_q,
    input  logic [ACC_W-1:0]        acc_q,
    input  logic signed [AMP_W-1:0] sin_raw,
    input  logic signed [AMP_W-1:0] cos_raw,
    input  logic signed [AMP_W-1:0] i_out,
    input  logic signed [AMP_W-1:0] q_out
);

    localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_zero_chk: assert (i_out == '0 && q_out == '0 && acc_q == '0);
        end
    end

    // R4
    acc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> acc_q == $past(acc_q) + $past(step_q));

    // R6
    step_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step_load)) |-> step_q == $past(step_word));

    // R6
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step_load)) |-> $stable(step_q));

    // R2
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rf_bit)) |-> (i_out == $past(cos_raw) && q_out == $past(sin_raw)));

    // R3
    negate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rf_bit)) |-> (i_out == -$past(cos_raw) && q_out == -$past(sin_raw)));

    // R7
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_out != MOST_NEG && q_out != MOST_NEG));

endmodule

bind onebit_iq_downconverter iq_dc_checker #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rf_bit    (rf_bit),
    .step_load (step_load),
    .step_word (step_word),
    .step_q    (step_q),
    .acc_q     (acc_q),
    .sin_raw   (sin_raw),
    .cos_raw   (cos_raw),
    .i_out     (i_out),
    .q_out     (q_out)
);

// File: tb/onebit_iq_downconverter_test.sv
`timescale 1ns/1ps
module onebit_iq_downconverter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rf_bit = 1'b0;
    logic        step_load = 1'b0;
    logic [31:0] step_word = '0;
    logic signed [11:0] i_out;
    logic signed [11:0] q_out;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] m_acc;
    logic [31:0] m_step;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    onebit_iq_downconverter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rf_bit    (rf_bit),
        .step_load (step_load),
        .step_word (step_word),
        .i_out     (i_out),
        .q_out     (q_out)
    );

    function automatic int ref_wave(input logic [31:0] acc, input bit cosine, input bit neg);
        real th;
        real v;
        int  r;
        th = 2.0 * 3.14159265358979 * (real'(acc[31:22]) + 0.5) / 1024.0;
        v  = cosine ? $cos(th) : $sin(th);
        r  = $rtoi($floor(2047.0 * v + 0.5));
        return neg ? -r : r;
    endfunction

    function automatic bit near(input int a, input int b);
        return (a - b <= 2) && (b - a <= 2);
    endfunction

    // One clock: drive inputs, predict, then sample 2 ns after the edge.
    task automatic step(input bit b, input bit ld, input logic [31:0] w, input string tag);
        int ei;
        int eq;
        rf_bit    = b;
        step_load = ld;
        step_word = w;
        ei = ref_wave(m_acc, 1'b1, b);
        eq = ref_wave(m_acc, 1'b0, b);
        m_acc = m_acc + m_step;
        if (ld) m_step = w;
        @(posedge clk);
        #2;
        step_load = 1'b0;
        n_checks++;
        if (!near(int'(i_out), ei) || !near(int'(q_out), eq) || i_out == -12'sd2048 || q_out == -12'sd2048) begin
            n_fails++;
            $display("FAIL %s: I=%0d Q=%0d expected I=%0d Q=%0d", tag, i_out, q_out, ei, eq);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        rf_bit = 1'b1;
        step_load = 1'b1;
        step_word = 32'h1234_0000;
        repeat (3) begin
            @(posedge clk);
            #2;
            n_checks++;
            if (i_out != 0 || q_out != 0) begin
                n_fails++;
                $display("FAIL R1: I=%0d Q=%0d expected I=0 Q=0", i_out, q_out);
            end
        end
        step_load = 1'b0;
        rst_n = 1'b1;
        m_acc = '0;
        m_step = '0;
        // R1: load during reset ignored -> phase stays at 0
        step(1'b0, 1'b0, '0, "R1");
        step(1'b0, 1'b0, '0, "R1");
    endtask

    task automatic t_static();
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0, '0, "R2");
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, '0, "R3");
    endtask

    task automatic t_sweep();
        step(1'b0, 1'b1, 32'h0040_0000, "R6");
        for (int k = 0; k < 1100; k++) step(k[3], 1'b0, '0, "R4_R5");
    endtask

    task automatic t_reload();
        step(1'b0, 1'b1, 32'h1234_5678, "R6");
        for (int k = 0; k < 300; k++) step(k[0], 1'b0, '0, "R6");
        step(1'b1, 1'b1, 32'hC000_0123, "R6");
        for (int k = 0; k < 40; k++) step(k[1], 1'b0, '0, "R6_R5");
    endtask

    task automatic t_pattern();
        step(1'b0, 1'b1, 32'h0A3D_70A4, "R2");
        for (int k = 0; k < 2000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], 1'b0, '0, lfsr[0] ? "R3_R7" : "R2_R7");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_static();
        t_sweep();
        t_reload();
        t_pattern();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule